// File: doc/BRIEF.md
# Parallel Test Access Switch for Wrapper Chains

This block sits between a wide parallel test access bus and a set of wrapper register groups around an embedded core. The bus has TAM_W input wires and TAM_W output wires. A wrapper instruction is loaded from the input wires in a single cycle. The instruction either selects one of N_GRP wrapper register groups or puts the switch in bypass.

In bypass, each input wire reaches its output wire through one flip-flop. When a group is selected, the input wires are steered to that group's parallel scan inputs and its scan outputs are multiplexed onto the output wires. A CHAIN_LEN-cell chain split across TAM_W wires loads in SEG_LEN = ceil(CHAIN_LEN / TAM_W) cycles. With the defaults (15 cells over 5 wires) this is 3 cycles.

A small sequencer has four states: ST_IDLE, ST_SHIFT, ST_APPLY and ST_DRAIN. Its transitions are:
- ST_IDLE to ST_SHIFT when `run` is high, no instruction load is requested, and a group is selected.
- ST_SHIFT to ST_APPLY after SEG_LEN shift cycles.
- ST_APPLY to ST_SHIFT if `run` is still high, which overlaps the shift-out of one response with the shift-in of the next pattern.
- ST_APPLY to ST_DRAIN if `run` is low.
- ST_DRAIN to ST_IDLE after SEG_LEN cycles.

The selected group gets shift enables during ST_SHIFT and ST_DRAIN, and capture and update enables during ST_APPLY.

Top module: `tamsw_top`

## Requirements
- R1: During and after reset, the instruction is bypass: `test_mode` is 0, `grp_sel` and all group enables are 0, and `tam_out` is 0 until bypass data arrives.
- R2: A high `ir_load` in ST_IDLE stores `tam_in[3:0]` at that clock edge. Code 4'b01gg selects group gg (`test_mode`=1, `grp_sel` one-hot at bit gg) from the next cycle. Every other code selects bypass.
- R3: In bypass, `tam_out` equals `tam_in` of the previous cycle, and all group enables and `chain_si` bits are 0.
- R4: With group g selected, `chain_si[g*TAM_W +: TAM_W]` follows `tam_in` in the same cycle and other groups' inputs are 0. `tam_out` shows `chain_so[g*TAM_W +: TAM_W]`.
- R5: `run` sampled high in ST_IDLE with a group selected gives exactly SEG_LEN (3) cycles of shift enable for that group only, beginning the next cycle.
- R6: Each complete load is followed by exactly one cycle in which capture and update are high for the selected group and shift is low.
- R7: After the apply cycle, `run` high starts the next pattern's shift at once, and the previous response appears on `tam_out` in shift order. `run` low gives SEG_LEN drain shift cycles and then ST_IDLE with no enables.
- R8: A stream of N patterns holds enables active for (SEG_LEN+1)*N + SEG_LEN cycles. That is 403 cycles for N=100, or 404 including the one-cycle instruction load.
- R9: `ir_load` outside ST_IDLE is ignored and the selection stays stable. `run` is ignored in bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset |
| ir_load | input | 1 | Load instruction from tam_in in this cycle |
| run | input | 1 | Request or continue a pattern stream |
| tam_in | input | TAM_W | Parallel bus, incoming wires |
| tam_out | output | TAM_W | Parallel bus, outgoing wires |
| test_mode | output | 1 | A group is selected (0 = functional/bypass) |
| grp_sel | output | N_GRP | One-hot group selection |
| grp_shift | output | N_GRP | Per-group shift enable |
| grp_capture | output | N_GRP | Per-group capture enable |
| grp_update | output | N_GRP | Per-group update enable |
| chain_si | output | N_GRP*TAM_W | Demultiplexed scan inputs, group-major |
| chain_so | input | N_GRP*TAM_W | Scan outputs of the groups, group-major |

## Verification
- **Instruction load:** a load becomes visible on `test_mode` and `grp_sel` one cycle after the edge that samples `ir_load`.
- **Bypass:** a bypass value appears on `tam_out` one edge after it is driven.
- **Routing:** `chain_si` and the selected-group `tam_out` path are combinational, so the bench checks them a moment after driving.
- **Sequencer:** shift enables start one edge after `run` is sampled in ST_IDLE, and the apply cycle follows the third shift cycle. Response bits appear on `tam_out` in the cycle after apply, one slot per cycle.
- **Sampling:** the bench drives and samples on the falling edge and walks its schedule slot by slot, so each comparison lands in the cycle where the value is due.

// File: rtl/tamsw_pkg.sv
package tamsw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_APPLY = 2'd2,
        ST_DRAIN = 2'd3
    } seq_state_e;

    // Number of shift cycles to fill a chain split over a given bus width
    function automatic int seg_len(input int chain_len, input int width);
        return (chain_len + width - 1) / width;
    endfunction

endpackage

// File: rtl/tamsw_ir.sv
module tamsw_ir #(
    parameter int IR_W  = 4,
    parameter int N_GRP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_req,
    input  logic             load_ok,
    input  logic [IR_W-1:0]  load_val,
    output logic             test_mode,
    output logic [N_GRP-1:0] grp_sel
);
    localparam int GIDX_W = (N_GRP > 1) ? $clog2(N_GRP) : 1;
    localparam int OPC_W  = IR_W - GIDX_W;
    localparam logic [OPC_W-1:0] OPC_SELECT = OPC_W'(1);
    localparam logic [IR_W-1:0]  IR_RESET   = '0;

    logic [IR_W-1:0]   ir_q;
    logic [OPC_W-1:0]  opc;
    logic [GIDX_W-1:0] gidx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q <= IR_RESET;
        end else if (load_req && load_ok) begin
            ir_q <= load_val;
        end
    end

    assign opc  = ir_q[IR_W-1:GIDX_W];
    assign gidx = ir_q[GIDX_W-1:0];

    always_comb begin
        grp_sel = '0;
        for (int g = 0; g < N_GRP; g++) begin
            grp_sel[g] = (opc == OPC_SELECT) && (gidx == GIDX_W'(g));
        end
        test_mode = |grp_sel;
    end

endmodule

// File: rtl/tamsw_seq.sv
module tamsw_seq
    import tamsw_pkg::*;
#(
    parameter int SEG_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ir_load,
    input  logic test_mode,
    output logic idle,
    output logic shifting,
    output logic applying
);
    localparam int CNT_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SEG_LEN - 1);

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (run && !ir_load && test_mode) begin
                    st_d  = ST_SHIFT;
                    cnt_d = '0;
                end
            end
            ST_SHIFT: begin
                if (cnt_q == CNT_LAST) begin
                    st_d = ST_APPLY;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_APPLY: begin
                cnt_d = '0;
                st_d  = run ? ST_SHIFT : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (cnt_q == CNT_LAST) begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_comb begin
        idle     = 1'b0;
        shifting = 1'b0;
        applying = 1'b0;
        unique case (st_q)
            ST_IDLE:  idle     = 1'b1;
            ST_SHIFT: shifting = 1'b1;
            ST_APPLY: applying = 1'b1;
            ST_DRAIN: shifting = 1'b1;
            default:  idle     = 1'b1;
        endcase
    end

endmodule

// File: rtl/tamsw_route.sv
module tamsw_route #(
    parameter int TAM_W = 5,
    parameter int N_GRP = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TAM_W-1:0]       tam_in,
    input  logic [N_GRP-1:0]       grp_sel,
    input  logic                   test_mode,
    input  logic [N_GRP*TAM_W-1:0] chain_so,
    output logic [N_GRP*TAM_W-1:0] chain_si,
    output logic [TAM_W-1:0]       tam_out
);
    logic [TAM_W-1:0] byp_q;
    logic [TAM_W-1:0] sel_so;

    // One bypass stage per wire
    for (genvar w = 0; w < TAM_W; w++) begin : g_byp
        logic stage_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= 1'b0;
            end else begin
                stage_q <= tam_in[w];
            end
        end
        assign byp_q[w] = stage_q;
    end

    // Demultiplex the input bus to the selected group
    for (genvar g = 0; g < N_GRP; g++) begin : g_demux
        assign chain_si[g*TAM_W +: TAM_W] = grp_sel[g] ? tam_in : '0;
    end

    // AND-OR multiplexer of group outputs
    always_comb begin
        sel_so = '0;
        for (int g = 0; g < N_GRP; g++) begin
            sel_so = sel_so | (chain_so[g*TAM_W +: TAM_W] & {TAM_W{grp_sel[g]}});
        end
    end

    assign tam_out = test_mode ? sel_so : byp_q;

endmodule

// File: rtl/tamsw_top.sv
module tamsw_top #(
    parameter int TAM_W     = 5,
    parameter int CHAIN_LEN = 15,
    parameter int N_GRP     = 4,
    parameter int IR_W      = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ir_load,
    input  logic                   run,
    input  logic [TAM_W-1:0]       tam_in,
    output logic [TAM_W-1:0]       tam_out,
    output logic                   test_mode,
    output logic [N_GRP-1:0]       grp_sel,
    output logic [N_GRP-1:0]       grp_shift,
    output logic [N_GRP-1:0]       grp_capture,
    output logic [N_GRP-1:0]       grp_update,
    output logic [N_GRP*TAM_W-1:0] chain_si,
    input  logic [N_GRP*TAM_W-1:0] chain_so
);
    localparam int SEG_LEN = tamsw_pkg::seg_len(CHAIN_LEN, TAM_W);

    logic idle, shifting, applying;

    tamsw_ir #(.IR_W(IR_W), .N_GRP(N_GRP)) ir_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (ir_load),
        .load_ok   (idle),
        .load_val  (tam_in[IR_W-1:0]),
        .test_mode (test_mode),
        .grp_sel   (grp_sel)
    );

    tamsw_seq #(.SEG_LEN(SEG_LEN)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .ir_load   (ir_load),
        .test_mode (test_mode),
        .idle      (idle),
        .shifting  (shifting),
        .applying  (applying)
    );

    tamsw_route #(.TAM_W(TAM_W), .N_GRP(N_GRP)) route_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tam_in    (tam_in),
        .grp_sel   (grp_sel),
        .test_mode (test_mode),
        .chain_so  (chain_so),
        .chain_si  (chain_si),
        .tam_out   (tam_out)
    );

    assign grp_shift   = shifting ? grp_sel : '0;
    assign grp_capture = applying ? grp_sel : '0;
    assign grp_update  = applying ? grp_sel : '0;

endmodule

// File: rtl/tamsw_chk.sv
module tamsw_chk #(
    parameter int TAM_W     = 5,
    parameter int CHAIN_LEN = 15,
    parameter int N_GRP     = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [TAM_W-1:0]       tam_in,
    input logic [TAM_W-1:0]       tam_out,
    input logic                   test_mode,
    input logic [N_GRP-1:0]       grp_sel,
    input logic [N_GRP-1:0]       grp_shift,
    input logic [N_GRP-1:0]       grp_capture,
    input logic [N_GRP-1:0]       grp_update,
    input logic [N_GRP*TAM_W-1:0] chain_si
);
    localparam int SEG_LEN = (CHAIN_LEN + TAM_W - 1) / TAM_W;
    localparam int RUN_W   = $clog2(SEG_LEN + 2);

    logic             past_ok;
    logic [RUN_W-1:0] shift_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok   <= 1'b0;
            shift_run <= '0;
        end else begin
            past_ok   <= 1'b1;
            shift_run <= (|grp_shift) ? shift_run + 1'b1 : '0;
        end
    end

    p_onehot_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_sel) && (test_mode == (|grp_sel)));

    p_bypass_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> (grp_shift == '0 && grp_capture == '0 && grp_update == '0 && chain_si == '0));

    p_bypass_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !test_mode) |-> (tam_out == $past(tam_in)));

    p_shift_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|grp_shift) |-> (shift_run < RUN_W'(SEG_LEN)));

    p_full_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|grp_capture) |-> (shift_run == RUN_W'(SEG_LEN)));

    p_apply_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|grp_capture) |=> (grp_capture == '0 && grp_update == '0));

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !((|grp_shift) && (|grp_capture)));

    p_apply_then_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|grp_capture) |=> (|grp_shift));

    p_sel_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grp_shift) || (|grp_capture)) |=> $stable(grp_sel));

endmodule

bind tamsw_top tamsw_chk #(
    .TAM_W     (TAM_W),
    .CHAIN_LEN (CHAIN_LEN),
    .N_GRP     (N_GRP)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tam_in      (tam_in),
    .tam_out     (tam_out),
    .test_mode   (test_mode),
    .grp_sel     (grp_sel),
    .grp_shift   (grp_shift),
    .grp_capture (grp_capture),
    .grp_update  (grp_update),
    .chain_si    (chain_si)
);

// File: tb/tamsw_top_tb_top.sv
module tamsw_top_tb_top;
    localparam int CLK_P = 10;
    localparam int TW    = 5;
    localparam int CL    = 15;
    localparam int NG    = 4;
    localparam int IRW   = 4;
    localparam int SEG   = (CL + TW - 1) / TW;

    logic clk = 1'b0;
    logic rst_n, ir_load, run;
    logic [TW-1:0]    tam_in, tam_out;
    logic             test_mode;
    logic [NG-1:0]    grp_sel, grp_shift, grp_capture, grp_update;
    logic [NG*TW-1:0] chain_si, chain_so;

    int  n_chk = 0;
    int  n_fail = 0;
    int  act_cnt = 0;
    bit  done = 0;

    always #(CLK_P/2) clk = ~clk;

    tamsw_top #(.TAM_W(TW), .CHAIN_LEN(CL), .N_GRP(NG), .IR_W(IRW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .run(run),
        .tam_in(tam_in), .tam_out(tam_out), .test_mode(test_mode),
        .grp_sel(grp_sel), .grp_shift(grp_shift), .grp_capture(grp_capture),
        .grp_update(grp_update), .chain_si(chain_si), .chain_so(chain_so)
    );

    function automatic logic [SEG-1:0] mask(input int g, input int w);
        return SEG'(((g * TW + w) * 3 + 1) % 8);
    endfunction

    function automatic logic [TW-1:0] pat(input int g, input int p, input int j);
        logic [TW-1:0] v;
        for (int w = 0; w < TW; w++) v[w] = (((p * 11 + j * 7 + w * 3 + g * 5) % 3) == 0);
        return v;
    endfunction

    function automatic logic [TW-1:0] resp(input int g, input int p, input int j);
        logic [TW-1:0] v;
        logic [SEG-1:0] m;
        v = pat(g, p, j);
        for (int w = 0; w < TW; w++) begin
            m = mask(g, w);
            v[w] = v[w] ^ m[SEG-1-j];
        end
        return v;
    endfunction

    // Model of the wrapper register groups outside the block
    logic [SEG-1:0] mdl [NG][TW];
    always_ff @(posedge clk) begin
        for (int g = 0; g < NG; g++) begin
            for (int w = 0; w < TW; w++) begin
                if (!rst_n) mdl[g][w] <= '0;
                else if (grp_shift[g]) mdl[g][w] <= {mdl[g][w][SEG-2:0], chain_si[g*TW+w]};
                else if (grp_capture[g]) mdl[g][w] <= mdl[g][w] ^ mask(g, w);
            end
        end
    end
    always_comb begin
        for (int g = 0; g < NG; g++)
            for (int w = 0; w < TW; w++)
                chain_so[g*TW+w] = mdl[g][w][SEG-1];
    end

    always @(negedge clk) if (rst_n && ((|grp_shift) || (|grp_capture))) act_cnt++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_ir(input logic [IRW-1:0] code);
        ir_load = 1'b1;
        tam_in  = TW'(code);
        @(negedge clk);
        ir_load = 1'b0;
    endtask

    task automatic run_patterns(input int g, input int n, input bit poke);
        logic [NG-1:0] gm;
        gm  = NG'(1) << g;
        run = 1'b1;
        tam_in = '0;
        @(negedge clk);
        for (int p = 0; p < n; p++) begin
            for (int j = 0; j < SEG; j++) begin
                chk(grp_shift == gm && grp_capture == '0, "R5 shift enable", grp_shift, gm);
                if (p > 0) chk(tam_out == resp(g, p-1, j), "R7 overlapped response", tam_out, resp(g, p-1, j));
                tam_in = pat(g, p, j);
                if (poke && p == 0 && j == 1) ir_load = 1'b1;
                @(negedge clk);
                ir_load = 1'b0;
            end
            chk(grp_capture == gm && grp_update == gm && grp_shift == '0, "R6 apply cycle",
                {grp_capture, grp_update, grp_shift}, {gm, gm, NG'(0)});
            if (p == n - 1) run = 1'b0;
            @(negedge clk);
        end
        for (int j = 0; j < SEG; j++) begin
            chk(grp_shift == gm, "R7 drain shift", grp_shift, gm);
            chk(tam_out == resp(g, n-1, j), "R7 drained response", tam_out, resp(g, n-1, j));
            @(negedge clk);
        end
        chk(grp_shift == '0 && grp_capture == '0 && grp_update == '0, "R7 back to idle",
            {grp_shift, grp_capture, grp_update}, 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ir_load = 1'b0; run = 1'b0; tam_in = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(test_mode == 1'b0 && grp_sel == '0, "R1 reset selection", {test_mode, grp_sel}, 0);
        chk(grp_shift == '0 && grp_capture == '0 && grp_update == '0, "R1 reset enables",
            {grp_shift, grp_capture, grp_update}, 0);
        chk(tam_out == '0, "R1 reset output", tam_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(test_mode == 1'b0, "R1 bypass after reset", test_mode, 0);

        // R3 bypass sweep, R9 run ignored in bypass
        run = 1'b1;
        for (int v = 0; v < (1 << TW); v++) begin
            tam_in = TW'(v);
            @(negedge clk);
            chk(tam_out == TW'(v), "R3 bypass delay", tam_out, v);
            chk(grp_shift == '0 && chain_si == '0, "R9 run ignored in bypass", grp_shift, 0);
        end
        run = 1'b0;

        // R2 decode sweep over every code
        for (int c = 0; c < (1 << IRW); c++) begin
            logic [NG-1:0] es;
            logic          et;
            et = ((c >> 2) == 1);
            es = et ? (NG'(1) << (c & 3)) : '0;
            load_ir(IRW'(c));
            chk(test_mode == et && grp_sel == es, "R2 instruction decode", {test_mode, grp_sel}, {et, es});
        end

        // R4 routing and pattern streams on every group
        for (int g = 0; g < NG; g++) begin
            load_ir(IRW'(4 + g));
            for (int x = 1; x < (1 << TW); x += 9) begin
                tam_in = TW'(x);
                #1;
                chk(chain_si == (NG*TW)'(x) << (g * TW), "R4 demux", chain_si, (NG*TW)'(x) << (g * TW));
                chk(tam_out == chain_so[g*TW +: TW], "R4 output mux", tam_out, chain_so[g*TW +: TW]);
                @(negedge clk);
            end
            run_patterns(g, g + 1, g == 1);
            if (g == 1) chk(test_mode == 1'b1 && grp_sel == NG'(2), "R9 load ignored while busy",
                            {test_mode, grp_sel}, {1'b1, NG'(2)});
            @(negedge clk);
        end

        // R8 long stream cycle count
        load_ir(IRW'(6));
        act_cnt = 0;
        run_patterns(2, 100, 1'b0);
        chk(act_cnt == (SEG + 1) * 100 + SEG, "R8 stream cycle count", act_cnt, (SEG + 1) * 100 + SEG);

        load_ir('0);
        chk(test_mode == 1'b0, "R2 return to bypass", test_mode, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule